// File: doc/BRIEF.md
# Paired-Page TLB Lookup

This block translates a 32-bit virtual address into a physical address by searching a small, fully associative array of translation entries. Each entry covers two adjacent pages, an even one and an odd one, under a single virtual tag. The page size of each entry is variable and is set by a per-entry page mask. Each half of the pair has its own frame number, valid bit and dirty bit. An entry applies to the current address space when its stored address-space ID equals the current one, or when the entry is marked global.

The lookup is purely combinational. A caller presents the address, a store flag, the current address-space ID and the number of entries in use, and reads back, in the same cycle, a result code, a physical address and a writable flag. Entries are loaded through a synchronous write port that takes an index and a complete entry. Refill policy, replacement choice and fault bookkeeping belong to the surrounding logic.

Top module: `pair_tlb_lookup`

## Requirements
- R1: An entry hits when its global bit is set or its stored 8-bit ASID equals `asid_i`, and its virtual tag equals `va_i` after both have the effective mask bits cleared.
- R2: The effective mask is the entry's page mask ORed with 0x1FFF. Bits 12:0 therefore never take part in the tag compare, and set page-mask bits widen the page.
- R3: The address bit at the most significant set position of the effective mask selects the half: 0 selects the even half and 1 selects the odd half.
- R4: When the selected half's valid bit is clear, the result is invalid (code 2), for loads and for stores alike.
- R5: A store to a valid half whose dirty bit is clear gives modify (code 3). A load to a valid half always gives match (code 0).
- R6: On match, `pa_o` is the selected frame ORed with `va_i` masked by (effective mask >> 1).
- R7: `writable_o` is 1 only on a match whose selected half has its dirty bit set.
- R8: Only indices below `in_use_i` are searched. When no searched entry hits, the result is no-match (code 1).
- R9: When several searched entries hit, the lowest index decides the outcome.
- R10: A write is visible to lookups from the cycle after its clock edge. A lookup in the same cycle as the write sees the old entry.
- R11: Reset clears every field of every entry to zero. When the result is not match, `pa_o` is 0 and `writable_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 32 | Virtual address to translate |
| store_i | input | 1 | 1 = store access, 0 = load |
| asid_i | input | 8 | Current address-space ID |
| in_use_i | input | 5 | Number of entries searched, counted from index 0 |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | 4 | Entry index to write |
| wr_page_mask_i | input | 32 | Page mask of the new entry |
| wr_vtag_i | input | 32 | Virtual tag of the new entry |
| wr_asid_i | input | 8 | ASID of the new entry |
| wr_global_i | input | 1 | Global bit of the new entry |
| wr_frame_even_i | input | 32 | Even-half frame address |
| wr_valid_even_i | input | 1 | Even-half valid bit |
| wr_dirty_even_i | input | 1 | Even-half dirty bit |
| wr_frame_odd_i | input | 32 | Odd-half frame address |
| wr_valid_odd_i | input | 1 | Odd-half valid bit |
| wr_dirty_odd_i | input | 1 | Odd-half dirty bit |
| pa_o | output | 32 | Translated physical address |
| writable_o | output | 1 | The page may be written |
| result_o | output | 3 | 0 match, 1 no-match, 2 invalid, 3 modify |

## Verification
The bench loads entries with 4 KB, 16 KB and 1 MB pairs and probes both halves of each. A design that picked the half from a fixed bit would hand back the wrong frame for the larger pages. A global entry placed above an ASID-private entry with the same tag checks two things: the private entry must win for its own ASID, and the global entry must serve every other ASID. Getting the priority wrong, or ignoring the ASID, shows up as the wrong frame. Shrinking the in-use count past an entry must turn its hit into a no-match. A lookup issued in the same cycle as a write must still see the old entry, so a write path that bypassed the array would show up there. Stores are sent to clean halves and loads to invalid halves, which separates modify from invalid; a design that ordered those two tests the wrong way would report the wrong code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned PA_W      = 32;
  localparam int unsigned ASID_W    = 8;
  localparam int unsigned PAIR_BITS = 13;  // smallest pair spans 2 x 4 KB

  localparam logic [VA_W-1:0] MIN_MASK = VA_W'((1 << PAIR_BITS) - 1);

  typedef struct packed {
    logic [VA_W-1:0]   page_mask;
    logic [VA_W-1:0]   vtag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PA_W-1:0]   frame_even;
    logic              valid_even;
    logic              dirty_even;
    logic [PA_W-1:0]   frame_odd;
    logic              valid_odd;
    logic              dirty_odd;
  } tlb_entry_t;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_MISS    = 3'd1,
    RES_INVALID = 3'd2,
    RES_MODIFY  = 3'd3
  } tlb_res_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  tlb_entry_t                        wr_entry_i,
  output tlb_entry_t [NUM_ENTRIES-1:0]      entries_o
);
  tlb_entry_t [NUM_ENTRIES-1:0] entries_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  entries_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    entries_q[g] <= wr_entry_i;
    end
  end

  assign entries_o = entries_q;
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
(
  input  logic [VA_W-1:0]   page_mask_i,
  input  logic [VA_W-1:0]   vtag_i,
  input  logic [ASID_W-1:0] entry_asid_i,
  input  logic              glob_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic              odd_o
);
  logic [VA_W-1:0] eff_mask;
  logic            asid_ok;
  logic            tag_ok;

  assign eff_mask = page_mask_i | MIN_MASK;
  assign asid_ok  = glob_i || (entry_asid_i == asid_i);
  assign tag_ok   = (vtag_i & ~eff_mask) == (va_i & ~eff_mask);
  assign hit_o    = asid_ok && tag_ok;
  // top set bit of a contiguous mask picks the half
  assign odd_o    = |(va_i & eff_mask & ~(eff_mask >> 1));
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES),
  localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic [NUM_ENTRIES-1:0] hit_i,
  input  logic [CNT_W-1:0]       in_use_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [NUM_ENTRIES-1:0] live;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_live
    assign live[g] = hit_i[g] && (CNT_W'(g) < in_use_i);
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (live[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pair_tlb_lookup.sv
module pair_tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES),
  localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   va_i,
  input  logic              store_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [CNT_W-1:0]  in_use_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VA_W-1:0]   wr_page_mask_i,
  input  logic [VA_W-1:0]   wr_vtag_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PA_W-1:0]   wr_frame_even_i,
  input  logic              wr_valid_even_i,
  input  logic              wr_dirty_even_i,
  input  logic [PA_W-1:0]   wr_frame_odd_i,
  input  logic              wr_valid_odd_i,
  input  logic              wr_dirty_odd_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              writable_o,
  output logic [2:0]        result_o
);
  tlb_entry_t                   wr_entry;
  tlb_entry_t [NUM_ENTRIES-1:0] entries;
  logic [NUM_ENTRIES-1:0]       hit;
  logic [NUM_ENTRIES-1:0]       odd;
  logic                         found;
  logic [IDX_W-1:0]             sel_idx;
  tlb_entry_t                   sel;
  logic                         sel_odd;
  logic [VA_W-1:0]              sel_mask;
  logic                         half_valid;
  logic                         half_dirty;
  logic [PA_W-1:0]              half_frame;
  tlb_res_e                     res;

  assign wr_entry = '{
    page_mask:  wr_page_mask_i,
    vtag:       wr_vtag_i,
    asid:       wr_asid_i,
    glob:       wr_global_i,
    frame_even: wr_frame_even_i,
    valid_even: wr_valid_even_i,
    dirty_even: wr_dirty_even_i,
    frame_odd:  wr_frame_odd_i,
    valid_odd:  wr_valid_odd_i,
    dirty_odd:  wr_dirty_odd_i
  };

  tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES)) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp i_cmp (
      .page_mask_i  (entries[g].page_mask),
      .vtag_i       (entries[g].vtag),
      .entry_asid_i (entries[g].asid),
      .glob_i       (entries[g].glob),
      .va_i         (va_i),
      .asid_i       (asid_i),
      .hit_o        (hit[g]),
      .odd_o        (odd[g])
    );
  end

  tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) i_pick (
    .hit_i    (hit),
    .in_use_i (in_use_i),
    .found_o  (found),
    .idx_o    (sel_idx)
  );

  assign sel        = entries[sel_idx];
  assign sel_odd    = odd[sel_idx];
  assign sel_mask   = sel.page_mask | MIN_MASK;
  assign half_valid = sel_odd ? sel.valid_odd  : sel.valid_even;
  assign half_dirty = sel_odd ? sel.dirty_odd  : sel.dirty_even;
  assign half_frame = sel_odd ? sel.frame_odd  : sel.frame_even;

  always_comb begin
    if (!found)                      res = RES_MISS;
    else if (!half_valid)            res = RES_INVALID;
    else if (store_i && !half_dirty) res = RES_MODIFY;
    else                             res = RES_MATCH;
  end

  assign result_o   = res;
  assign pa_o       = (res == RES_MATCH) ? (half_frame | PA_W'(va_i & (sel_mask >> 1))) : '0;
  assign writable_o = (res == RES_MATCH) && half_dirty;

  assert_modify_needs_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o == RES_MODIFY |-> store_i);
  assert_page_offset_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o == RES_MATCH |-> pa_o[PAIR_BITS-2:0] == va_i[PAIR_BITS-2:0]);
  assert_writable_on_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writable_o |-> result_o == RES_MATCH);
  assert_empty_misses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_use_i == '0 |-> result_o == RES_MISS);
  assert_quiet_unless_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o != RES_MATCH |-> (pa_o == '0 && !writable_o));
  assert_code_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o <= 3'd3);
endmodule

// File: tb/test_pair_tlb_lookup.sv
module test_pair_tlb_lookup;
  localparam int N = 16;

  typedef struct {
    logic [31:0] pmask, vtag, fe, fo;
    logic [7:0]  asid;
    logic        g, ve, de, vo, dov;
  } ent_t;

  typedef struct {
    logic [31:0] pa;
    logic        wr;
    logic [2:0]  res;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] va = 0;
  logic        st = 0;
  logic [7:0]  asid = 0;
  logic [4:0]  in_use = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [31:0] wpm = 0, wvt = 0, wfe = 0, wfo = 0;
  logic [7:0]  wasid = 0;
  logic        wg = 0, wve = 0, wde = 0, wvo = 0, wdo = 0;
  logic [31:0] pa;
  logic        writable;
  logic [2:0]  result;

  ent_t mdl [N];
  exp_t q[$];
  int checks = 0, fails = 0;
  bit pend = 0;
  int pend_idx;
  ent_t pend_e;
  bit done = 0;

  always #5 clk = ~clk;

  pair_tlb_lookup i_pair_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .store_i(st), .asid_i(asid),
    .in_use_i(in_use), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_page_mask_i(wpm), .wr_vtag_i(wvt), .wr_asid_i(wasid), .wr_global_i(wg),
    .wr_frame_even_i(wfe), .wr_valid_even_i(wve), .wr_dirty_even_i(wde),
    .wr_frame_odd_i(wfo), .wr_valid_odd_i(wvo), .wr_dirty_odd_i(wdo),
    .pa_o(pa), .writable_o(writable), .result_o(result)
  );

  function automatic exp_t predict(logic [31:0] a, logic s, logic [7:0] id, int n, string tag);
    exp_t r;
    r.pa = 0; r.wr = 0; r.res = 3'd1; r.tag = tag;
    for (int i = 0; i < n; i++) begin
      logic [31:0] m;
      logic od, v, d;
      logic [31:0] f;
      m = mdl[i].pmask | 32'h1FFF;
      if ((mdl[i].g || mdl[i].asid == id) && ((mdl[i].vtag & ~m) == (a & ~m))) begin
        od = |(a & m & ~(m >> 1));
        v = od ? mdl[i].vo : mdl[i].ve;
        d = od ? mdl[i].dov : mdl[i].de;
        f = od ? mdl[i].fo : mdl[i].fe;
        if (!v) r.res = 3'd2;
        else if (s && !d) r.res = 3'd3;
        else begin r.res = 3'd0; r.pa = f | (a & (m >> 1)); r.wr = d; end
        return r;
      end
    end
    return r;
  endfunction

  // one cycle: optional write plus one lookup, expectation from the model
  task automatic step(bit do_wr, int idx, ent_t e, logic [31:0] a, logic s,
                      logic [7:0] id, int n, string tag);
    @(posedge clk); #1;
    if (pend) begin mdl[pend_idx] = pend_e; pend = 0; end
    wr_en = do_wr; wr_idx = 4'(idx);
    wpm = e.pmask; wvt = e.vtag; wasid = e.asid; wg = e.g;
    wfe = e.fe; wve = e.ve; wde = e.de; wfo = e.fo; wvo = e.vo; wdo = e.dov;
    if (do_wr) begin pend = 1; pend_idx = idx; pend_e = e; end
    va = a; st = s; asid = id; in_use = 5'(n);
    q.push_back(predict(a, s, id, n, tag));
  endtask

  task automatic look(logic [31:0] a, logic s, logic [7:0] id, int n, string tag);
    ent_t z;
    z = '{pmask:0, vtag:0, fe:0, fo:0, asid:0, g:0, ve:0, de:0, vo:0, dov:0};
    step(0, 0, z, a, s, id, n, tag);
  endtask

  task automatic load(int idx, ent_t e);
    step(1, idx, e, 32'h0, 0, 8'h0, 0, "R10 load");
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pa !== e.pa || writable !== e.wr || result !== e.res) begin
        fails++;
        $display("FAIL %s: got res=%0d pa=%h wr=%b, expected res=%0d pa=%h wr=%b",
                 e.tag, result, pa, writable, e.res, e.pa, e.wr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ent_t e0, e1, e2, e3, e3b;
    for (int i = 0; i < N; i++)
      mdl[i] = '{pmask:0, vtag:0, fe:0, fo:0, asid:0, g:0, ve:0, de:0, vo:0, dov:0};
    e0  = '{pmask:32'h0, vtag:32'h0040_0000, asid:8'd5, g:0,
            fe:32'h1000_0000, ve:1, de:1, fo:32'h2000_0000, vo:1, dov:0};
    e1  = '{pmask:32'h0000_6000, vtag:32'h0080_0000, asid:8'd0, g:1,
            fe:32'h3000_0000, ve:0, de:0, fo:32'h3001_0000, vo:1, dov:1};
    e2  = '{pmask:32'h0, vtag:32'h0040_0000, asid:8'd5, g:1,
            fe:32'h5000_0000, ve:1, de:1, fo:32'h5000_2000, vo:1, dov:1};
    e3  = '{pmask:32'h001F_E000, vtag:32'h0100_0000, asid:8'd9, g:0,
            fe:32'h4000_0000, ve:1, de:1, fo:32'h4010_0000, vo:1, dov:0};
    e3b = '{pmask:32'h0, vtag:32'h0100_0000, asid:8'd9, g:0,
            fe:32'h6000_0000, ve:1, de:0, fo:32'h6000_2000, vo:0, dov:0};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state: zeroed entry 0 hits tag 0 with valid clear
    look(32'h0000_1000, 0, 8'd0, 16, "R11 reset entry invalid");
    look(32'h0000_1000, 0, 8'd0, 0,  "R8 empty array miss");
    load(0, e0); load(1, e1); load(2, e2); load(3, e3);
    look(32'h0040_0abc, 0, 8'd5, 4, "R1 asid match even load");
    look(32'h0040_0abc, 1, 8'd5, 4, "R7 store dirty even writable");
    look(32'h0040_1123, 0, 8'd5, 4, "R3 odd half load clean");
    look(32'h0040_1123, 1, 8'd5, 4, "R5 store clean half modify");
    look(32'h0040_0abc, 0, 8'd7, 4, "R9 global later entry for other asid");
    look(32'h0040_1ff0, 1, 8'd5, 4, "R9 first hit wins");
    look(32'h0080_2345, 0, 8'd3, 4, "R4 invalid even half load");
    look(32'h0080_2345, 1, 8'd3, 4, "R4 invalid even half store");
    look(32'h0080_5678, 1, 8'd3, 4, "R2 R3 16K odd half");
    look(32'h0080_8000, 0, 8'd3, 4, "R2 outside 16K pair miss");
    look(32'h0105_4321, 0, 8'd9, 4, "R6 1M even offset");
    look(32'h011A_BCDE, 0, 8'd9, 4, "R6 1M odd offset");
    look(32'h011A_BCDE, 1, 8'd9, 4, "R5 1M odd store modify");
    look(32'h0105_4321, 0, 8'd8, 4, "R1 asid mismatch miss");
    look(32'h0105_4321, 0, 8'd9, 3, "R8 beyond in-use miss");
    look(32'h0100_0000, 0, 8'd9, 16, "R8 full count");
    // rewrite entry 3 and look in the same cycle, then the next
    step(1, 3, e3b, 32'h0100_3004, 0, 8'd9, 4, "R10 same cycle sees old");
    look(32'h0100_3004, 0, 8'd9, 4, "R10 next cycle sees new");
    look(32'h0100_0004, 1, 8'd9, 4, "R5 new entry clean store");
    look(32'h0100_0004, 0, 8'd9, 4, "R7 clean load not writable");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule